// File: doc/BRIEF.md
# Single-Input-Change Test Pattern Generator

This block is a built-in self-test stimulus source. Each vector it produces differs from the one before it in a single bit, which keeps switching activity in the circuit under test low while a test runs. Two registers build every vector. A shift register fills with ones and then drains back to zeros, one stage per enabled clock. A seed register holds one value for a whole sweep. The output is the bitwise XOR of the two.

A phase counter runs modulo 2·WIDTH+1. It decides whether ones or zeros enter the shift register, and it produces the single-cycle strobe that moves the seed to its next value, so the whole block runs on one clock. The integrating logic raises the enable for every vector it wants to apply, reads `vec_o` after the edge, and can use `seed_adv_o` to mark the boundaries between sweeps.

Top module: `sic_tpg`

## Requirements
- R1: A clock edge with `rst_ni` low clears the phase, the shift register and the seed, so that `vec_o` reads all zeros and `seed_adv_o` is low afterwards. Reset takes priority over `en_i`.
- R2: In phase p, for 0 ≤ p ≤ WIDTH, the shift pattern has its p lowest bits set. Bit 0 is the first stage, and ones enter there. `vec_o` equals seed XOR that pattern.
- R3: In phase WIDTH+q, for 1 ≤ q ≤ WIDTH, the shift pattern is all ones with its q lowest bits cleared, because zeros enter at bit 0. `vec_o` equals seed XOR that pattern.
- R4: Each enabled edge advances the phase by one. Phase 2·WIDTH is followed by phase 0, so the shift pattern repeats with a period of 2·WIDTH+1 enabled cycles and the all-zero pattern appears twice in a row across the boundary.
- R5: Within one sweep, every enabled edge changes exactly one bit of `vec_o`. Across the sweep boundary, the change equals the old seed XOR the new seed.
- R6: The seed stays constant for all 2·WIDTH+1 vectors of a sweep. At the sweep boundary it increases by one as an unsigned WIDTH-bit number and wraps from all ones to zero.
- R7: `seed_adv_o` is high exactly when `en_i` is high and the phase is 2·WIDTH, so it is high once in every 2·WIDTH+1 enabled cycles. The seed changes on that edge.
- R8: While `en_i` is low, every register holds its value: `vec_o` does not change and `seed_adv_o` is low.
- R9: A reset in the middle of a sweep restarts the block at phase 0 with seed 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock for every register |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance one vector on this edge |
| vec_o | output | WIDTH | Test vector, seed XOR shift pattern |
| seed_adv_o | output | 1 | The seed takes its next value on this edge |

## Verification
The main pattern is a run with the enable held high. It covers all 256 seeds of the default 8-bit configuration plus the wrap back to seed 0. This run separates the fill phases from the drain phases, the seed-hold rule from the seed-increment rule, and the one-bit changes inside a sweep from the multi-bit change at each boundary. Pauses with the enable low, placed in the middle of a fill and in the middle of a drain, show whether anything moves while the block is idle. A reset with the enable high, in the middle of a sweep, shows that reset both restarts the phase and clears the seed.

// File: rtl/sic_pkg.sv
// Shared types for the single-input-change pattern generator.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package sic_pkg;

    // Direction of the thermometer sweep: ones entering or zeros entering.
    typedef enum logic {
        SWEEP_FILL  = 1'b0,
        SWEEP_DRAIN = 1'b1
    } sweep_dir_e;

endpackage

// File: rtl/sic_phase_ctr.sv
// Modulo-(2*WIDTH+1) phase counter.
// Advances once per step. Reports whether the sweep is filling or draining,
// and flags the final phase of a sweep.
// Assumes: step_i is a single-cycle qualifier that is synchronous to clk_i.
module sic_phase_ctr
    import sic_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  step_i,
    output logic [$clog2(2*WIDTH+1)-1:0]          phase_o,
    output sweep_dir_e                            dir_o,
    output logic                                  last_o
);
    localparam int LAST = 2 * WIDTH;
    localparam int PW   = $clog2(LAST + 1);

    logic [PW-1:0] phase_q;

    // Count phases 0..LAST, then wrap to 0.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
        end else if (step_i) begin
            if (phase_q == PW'(LAST)) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // Ones are fed for the first WIDTH phases and zeros for the rest.
    always_comb begin
        dir_o = (phase_q < PW'(WIDTH)) ? SWEEP_FILL : SWEEP_DRAIN;
    end

    assign last_o  = (phase_q == PW'(LAST));
    assign phase_o = phase_q;

endmodule

// File: rtl/sic_thermo_sreg.sv
// Thermometer shift register.
// Stage 0 takes the feed bit, and each later stage takes the stage before it.
// Assumes: the owner drives feed_i to 1 while filling and to 0 while draining.
module sic_thermo_sreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             feed_i,
    output logic [WIDTH-1:0] sr_o
);
    logic [WIDTH-1:0] stage_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_stage
        logic stage_d;

        // Select the serial input of this stage.
        if (g == 0) begin : g_head
            assign stage_d = feed_i;
        end else begin : g_tail
            assign stage_d = stage_q[g-1];
        end

        // One flop per stage. It is cleared by reset and shifts on each step.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                stage_q[g] <= 1'b0;
            end else if (step_i) begin
                stage_q[g] <= stage_d;
            end
        end
    end

    assign sr_o = stage_q;

endmodule

// File: rtl/sic_seed_ctr.sv
// Seed register: a WIDTH-bit binary up-counter that moves once per sweep.
// Assumes: adv_i is high for one enabled cycle per sweep.
module sic_seed_ctr #(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             adv_i,
    output logic [WIDTH-1:0] seed_o
);
    logic [WIDTH-1:0] seed_q;

    // Hold the seed for a sweep, then increment it. It wraps naturally.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seed_q <= '0;
        end else if (adv_i) begin
            seed_q <= seed_q + 1'b1;
        end
    end

    assign seed_o = seed_q;

endmodule

// File: rtl/sic_tpg.sv
// Top level of the single-input-change test pattern generator.
// vec_o is seed XOR thermometer. Consecutive vectors inside a sweep differ in one bit.
// Assumes: a single clock domain, and that en_i is synchronous to clk_i.
module sic_tpg
    import sic_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    output logic [WIDTH-1:0] vec_o,
    output logic             seed_adv_o
);
    localparam int PW = $clog2(2 * WIDTH + 1);

    logic [PW-1:0]    phase;
    sweep_dir_e       dir;
    logic             last;
    logic             feed;
    logic [WIDTH-1:0] sr_q;
    logic [WIDTH-1:0] seed_q;

    sic_phase_ctr #(.WIDTH(WIDTH)) u_phase (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .step_i  (en_i),
        .phase_o (phase),
        .dir_o   (dir),
        .last_o  (last)
    );

    // AND gate on the first stage: feed ones only during the fill half.
    assign feed = (dir == SWEEP_FILL);

    sic_thermo_sreg #(.WIDTH(WIDTH)) u_sreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .step_i (en_i),
        .feed_i (feed),
        .sr_o   (sr_q)
    );

    // The seed moves on the enabled edge that closes a sweep.
    assign seed_adv_o = en_i & last;

    sic_seed_ctr #(.WIDTH(WIDTH)) u_seed (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (seed_adv_o),
        .seed_o (seed_q)
    );

    // Combine the held seed with the sweep pattern.
    assign vec_o = seed_q ^ sr_q;

    logic unused_phase;
    assign unused_phase = ^phase;

endmodule

// File: rtl/sic_tpg_chk.sv
// Property checker for sic_tpg. It is bound into every instance of the top.
// Assumes: the seed register is reachable as seed_q inside the top.
module sic_tpg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [WIDTH-1:0] vec,
    input logic             seed_adv,
    input logic [WIDTH-1:0] seed
);
    localparam int LAST = 2 * WIDTH;
    localparam int PW   = $clog2(LAST + 1);

    logic [PW-1:0] cnt_q;

    // Independent count of the enabled cycles within the current sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= (cnt_q == PW'(LAST)) ? '0 : cnt_q + 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (vec == '0) && (seed == '0));

    a_r5_single_change: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_adv) |=> ($countones(vec ^ $past(vec)) == 1));

    a_r6_seed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !seed_adv) |=> $stable(seed));

    a_r6_seed_inc: assert property (@(posedge clk) disable iff (!rst_n)
        seed_adv |=> (seed == $past(seed) + 1'b1));

    a_r7_period: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (seed_adv == (cnt_q == PW'(LAST))));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(vec));

    a_r8_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !seed_adv);

endmodule

bind sic_tpg sic_tpg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .en       (en_i),
    .vec      (vec_o),
    .seed_adv (seed_adv_o),
    .seed     (seed_q)
);

// File: tb/tb_sic_tpg.sv
// Self-checking bench for sic_tpg with WIDTH=8. Expected values come from arithmetic.
module tb_sic_tpg;
    localparam int W = 8;
    localparam int P = 2 * W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] vec;
    logic         adv;

    int           total = 0;
    int           bad = 0;
    int           k = 0;
    logic [W-1:0] last_vec = '0;

    sic_tpg #(.WIDTH(W)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .en_i       (en),
        .vec_o      (vec),
        .seed_adv_o (adv)
    );

    always #5 clk = ~clk;

    function automatic logic [W-1:0] thermo(input int p);
        logic [W-1:0] ones;
        ones = '1;
        if (p <= W) return ~(ones << p);
        return ones << (p - W);
    endfunction

    function automatic logic [W-1:0] seed_of(input int n);
        return W'((n / P) % (1 << W));
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (k=%0d)", tag, act, exp, k);
        end
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    // One clock cycle with enable e. The cycle starts and ends at a falling edge.
    task automatic tick(input logic e);
        int p;
        en = e;
        #1;
        p = k % P;
        if (e) chk("R7", W'(adv), W'(p == P - 1));
        else   chk("R8", W'(adv), '0);
        @(posedge clk);
        if (e) k++;
        @(negedge clk);
        p = k % P;
        if (p <= W) chk("R2", vec, seed_of(k) ^ thermo(p));
        else        chk("R3", vec, seed_of(k) ^ thermo(p));
        if (e) begin
            if (p == 0) begin
                chk("R4", vec ^ seed_of(k), '0);
                chk("R6", vec ^ last_vec, seed_of(k) ^ seed_of(k - 1));
            end else begin
                chk("R5", W'($countones(vec ^ last_vec)), W'(1));
            end
        end else begin
            chk("R8", vec, last_vec);
        end
        last_vec = vec;
    endtask

    task automatic do_reset(input logic e);
        rst_n = 1'b0;
        en = e;
        repeat (2) @(posedge clk);
        @(negedge clk);
        k = 0;
        chk("R1", vec, '0);
        chk("R1", W'(adv), '0);
        last_vec = vec;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0);
        // Fill part way, then pause in the middle of the fill (R8).
        for (int i = 0; i < 5; i++) tick(1'b1);
        for (int i = 0; i < 4; i++) tick(1'b0);
        // Move into the drain half, then pause again.
        for (int i = 0; i < 7; i++) tick(1'b1);
        for (int i = 0; i < 3; i++) tick(1'b0);
        // Cover every seed and the wrap back to zero (R6, R4).
        while (k < P * (1 << W) + 2 * P) tick(1'b1);
        chk("R6", seed_of(k), W'(2 % (1 << W)));
        // Reset in the middle of a sweep with the enable held high (R9).
        for (int i = 0; i < 6; i++) tick(1'b1);
        do_reset(1'b1);
        chk("R9", vec, '0);
        for (int i = 0; i < 2 * P; i++) tick(1'b1);
        summary();
        $finish;
    end

endmodule